// File: doc/BRIEF.md
# Transmit/Receive Changeover Controller

This block decides, cycle by cycle, whether a CW/RTTY radio terminal is transmitting or receiving. It watches the operator's SEND contact on the three-position send/auto/receive selector, the CW/RTTY mode switch and the telegraph key. All three are active-low contacts and are debounced against a 1 ms tick. It also watches a single-cycle pulse that the character sender raises each time it puts a character on the air.

Any key operation or sent character starts a hold timer, and every later one reloads it to its full length. The transmitter stays enabled until that timer runs out. In the SEND position the transmitter is forced on for as long as the contact is closed. The timer is kept loaded during that time, so the transmitter drops one hold period after the operator moves the selector to AUTO or RECEIVE. The AUTO and RECEIVE positions behave the same way, so only the SEND contact is an input.

While the station transmits, or while RTTY mode is selected, the block closes the gate through which the CW tone decoder output reaches the receive path.

Top module: `txrx_changeover`

## Requirements
- R1: While reset is held (synchronous, active low), tx_en_o, tone_gate_o, rx_open_o and cw_rx_o are all 0, and the hold timer is cleared.
- R2: Holding key_n_i low (key pressed) for at least DEB_TICKS ticks drives tx_en_o to 1.
- R3: After the key is released, with no further activity, tx_en_o returns to 0 between DEB_TICKS+HOLD_TICKS-2 and DEB_TICKS+HOLD_TICKS+1 ticks after the release.
- R4: A key operation during the hold period reloads the timer to its full length. The drop then follows the last release within the R3 window.
- R5: A one-cycle pulse on char_sent_i raises tx_en_o within 3 clock cycles and reloads the timer. Without further activity, tx_en_o drops HOLD_TICKS-1 to HOLD_TICKS+1 ticks after the last pulse.
- R6: While send_n_i is low (SEND position, debounced), tx_en_o stays 1 for any length of time, whatever the timer holds.
- R7: When send_n_i returns high (AUTO or RECEIVE), tx_en_o falls between DEB_TICKS+HOLD_TICKS-2 and DEB_TICKS+HOLD_TICKS+1 ticks later.
- R8: tone_gate_o equals tx_en_o while RTTY mode is selected (rtty_n_i low, debounced) and is 0 in CW mode.
- R9: rx_open_o is 1 only when tx_en_o is 0 and CW mode is selected. cw_rx_o equals cw_tone_i when rx_open_o is 1 and is 0 otherwise.
- R10: A level on key_n_i, send_n_i or rtty_n_i that lasts fewer than DEB_TICKS ticks has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| send_n_i | input | 1 | SEND contact of the selector, low = SEND |
| rtty_n_i | input | 1 | Mode contact, low = RTTY, high = CW |
| key_n_i | input | 1 | Telegraph key, low = pressed |
| char_sent_i | input | 1 | One-cycle pulse per character sent |
| cw_tone_i | input | 1 | CW tone decoder output |
| tx_en_o | output | 1 | Transmitter enable |
| tone_gate_o | output | 1 | Transmit gate for the RTTY tone generator |
| rx_open_o | output | 1 | CW receive gate is open |
| cw_rx_o | output | 1 | Decoder output after the receive gate |

## Verification
A hold counter stuck or reloaded wrongly shows up as a transmitter-enable drop outside a window of plus or minus two ticks around the hold period. The bench measures that drop after key release, after the last character pulse and after the selector leaves SEND. A debouncer that accepts a short level change would raise tx_en_o or open the receive gate within about ten ticks of the glitch. A gate stuck open would pass a decoder tone to cw_rx_o in the same cycle that it is sampled during transmission or in RTTY mode.

// File: rtl/txrx_pkg.sv
// Shared definitions for the changeover controller.
// Assumes: the three debounced contacts are kept in one vector indexed by db_idx_e.
package txrx_pkg;
    localparam int NUM_DB = 3;
    typedef enum logic [1:0] {
        DB_KEY  = 2'd0,
        DB_SEND = 2'd1,
        DB_RTTY = 2'd2
    } db_idx_e;
endpackage

// File: rtl/txrx_debounce.sv
// Synchronises one active-low contact and accepts a new level only after it
// has been seen for DEB_TICKS consecutive ticks.
// Assumes: tick_i is a single-cycle pulse; an open contact reads high.
module txrx_debounce #(
    parameter int DEB_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_n_i,
    output logic on_o
);
    localparam int CW = (DEB_TICKS < 2) ? 1 : $clog2(DEB_TICKS);

    logic [1:0]    sync_q;
    logic          on_q;
    logic [CW-1:0] cnt_q;
    logic          level_on;

    assign level_on = ~sync_q[1];
    assign on_o     = on_q;

    // Two-stage synchroniser for the asynchronous contact.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_n_i};
    end

    // Count ticks while the level differs; take it over after DEB_TICKS of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
        end else if (level_on == on_q) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == CW'(DEB_TICKS - 1)) begin
                on_q  <= level_on;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R10: the accepted level only changes on a tick, after a differing level.
    assert_flip_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(on_q) |-> ($past(tick_i) && ($past(level_on) != $past(on_q))));
endmodule

// File: rtl/txrx_hold_timer.sv
// Release delay timer: reloaded to HOLD_TICKS while load_i is high, then counts
// down once per tick. busy_o is high while the count is non-zero.
// Assumes: tick_i is a single-cycle pulse.
module txrx_hold_timer #(
    parameter int HOLD_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD_TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign busy_o = (cnt_q != '0);

    // Reload on activity, otherwise count down on each tick down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load_i)            cnt_q <= CW'(HOLD_TICKS);
        else if (tick_i && busy_o)  cnt_q <= cnt_q - 1'b1;
    end

    // R3: the timer expires only on a tick and never while it is being loaded.
    assert_expire_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(tick_i) && !$past(load_i)));

    // R4: any activity leaves the timer running on the next cycle.
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);
endmodule

// File: rtl/txrx_changeover.sv
// Transmit/receive changeover controller. Debounces the SEND, mode and key
// contacts, keeps the transmitter on while SEND is closed or the hold timer
// runs, gates the tone generator in RTTY mode and closes the CW receive gate
// while transmitting or in RTTY mode.
// Assumes: tick_i pulses once per millisecond; char_sent_i is already synchronous.
module txrx_changeover
    import txrx_pkg::*;
#(
    parameter int DEB_TICKS  = 8,
    parameter int HOLD_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic send_n_i,
    input  logic rtty_n_i,
    input  logic key_n_i,
    input  logic char_sent_i,
    input  logic cw_tone_i,
    output logic tx_en_o,
    output logic tone_gate_o,
    output logic rx_open_o,
    output logic cw_rx_o
);
    logic [NUM_DB-1:0] raw_n;
    logic [NUM_DB-1:0] on;
    logic              load;
    logic              busy;
    logic              tx_d;
    logic              tx_q, tone_q, rx_q;

    assign raw_n[DB_KEY]  = key_n_i;
    assign raw_n[DB_SEND] = send_n_i;
    assign raw_n[DB_RTTY] = rtty_n_i;

    // One debouncer per contact.
    for (genvar g = 0; g < NUM_DB; g++) begin : g_db
        txrx_debounce #(.DEB_TICKS(DEB_TICKS)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .raw_n_i (raw_n[g]),
            .on_o    (on[g])
        );
    end

    // Any activity, including SEND, keeps the hold timer loaded.
    assign load = on[DB_KEY] | on[DB_SEND] | char_sent_i;

    txrx_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .load_i (load),
        .busy_o (busy)
    );

    assign tx_d = on[DB_SEND] | load | busy;

    // Register the three gates so they change together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= 1'b0;
            tone_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            tx_q   <= tx_d;
            tone_q <= tx_d & on[DB_RTTY];
            rx_q   <= ~tx_d & ~on[DB_RTTY];
        end
    end

    assign tx_en_o     = tx_q;
    assign tone_gate_o = tone_q;
    assign rx_open_o   = rx_q;
    assign cw_rx_o     = cw_tone_i & rx_q;

    // R6: a debounced SEND contact forces the transmitter on next cycle.
    assert_send_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        on[DB_SEND] |=> tx_en_o);

    // R7: the transmitter never drops while SEND was closed.
    assert_no_drop_in_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en_o) |-> !$past(on[DB_SEND]));

    // R8: the tone gate is never open without the transmitter.
    assert_tone_needs_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tone_gate_o |-> tx_en_o);

    // R9: no decoded tone leaves the block while transmitting.
    assert_rx_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> !cw_rx_o);
endmodule

// File: tb/txrx_changeover_tb.sv
module txrx_changeover_tb;
    localparam int DEB  = 8;
    localparam int HOLD = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic send_n_i = 1'b1, rtty_n_i = 1'b1, key_n_i = 1'b1;
    logic char_sent_i = 1'b0, cw_tone_i = 1'b0;
    logic tx_en_o, tone_gate_o, rx_open_o, cw_rx_o;
    logic [1:0] div = 2'd0;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // 1 ms tick stand-in: one pulse every 4 clocks.
    always @(posedge clk) begin
        if (!rst_n) begin div <= 2'd0; tick_i <= 1'b0; end
        else begin div <= div + 2'd1; tick_i <= (div == 2'd3); end
    end

    txrx_changeover #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .send_n_i(send_n_i),
        .rtty_n_i(rtty_n_i), .key_n_i(key_n_i), .char_sent_i(char_sent_i),
        .cw_tone_i(cw_tone_i), .tx_en_o(tx_en_o), .tone_gate_o(tone_gate_o),
        .rx_open_o(rx_open_o), .cw_rx_o(cw_rx_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick_i) @(negedge clk);
        end
    endtask

    task automatic measure_fall(output int n);
        n = 0;
        while (tx_en_o && n < 3000) begin
            @(negedge clk);
            if (tick_i) n++;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 tx_en in reset", tx_en_o, 1'b0);
        chk("R1 tone_gate in reset", tone_gate_o, 1'b0);
        chk("R1 rx_open in reset", rx_open_o, 1'b0);
        chk("R1 cw_rx in reset", cw_rx_o, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 tx_en after reset", tx_en_o, 1'b0);
        cw_tone_i = 1'b1;
        @(negedge clk);
        chk("R9 rx_open idle CW", rx_open_o, 1'b1);
        chk("R9 cw_rx passes tone", cw_rx_o, 1'b1);
        cw_tone_i = 1'b0;
        @(negedge clk);
        chk("R9 cw_rx follows tone low", cw_rx_o, 1'b0);
    endtask

    task automatic t_key;
        int n;
        key_n_i = 1'b0;
        ticks(DEB + 3);
        cw_tone_i = 1'b1;
        @(negedge clk);
        chk("R2 tx_en on key", tx_en_o, 1'b1);
        chk("R8 tone_gate low in CW", tone_gate_o, 1'b0);
        chk("R9 rx closed while tx", rx_open_o, 1'b0);
        chk("R9 cw_rx blocked while tx", cw_rx_o, 1'b0);
        key_n_i = 1'b1;
        measure_fall(n);
        chk_rng("R3 hold after key release", n, DEB + HOLD - 2, DEB + HOLD + 1);
        repeat (2) @(negedge clk);
        chk("R9 rx reopens", cw_rx_o, 1'b1);
        cw_tone_i = 1'b0;
    endtask

    task automatic t_retrigger;
        int n;
        key_n_i = 1'b0; ticks(12); key_n_i = 1'b1;
        ticks(500);
        chk("R4 tx still on mid hold", tx_en_o, 1'b1);
        key_n_i = 1'b0; ticks(12); key_n_i = 1'b1;
        measure_fall(n);
        chk_rng("R4 hold restarted from second release", n, DEB + HOLD - 2, DEB + HOLD + 1);
    endtask

    task automatic t_char;
        int n;
        char_sent_i = 1'b1; @(negedge clk); char_sent_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 tx_en on char pulse", tx_en_o, 1'b1);
        ticks(600);
        char_sent_i = 1'b1; @(negedge clk); char_sent_i = 1'b0;
        measure_fall(n);
        chk_rng("R5 hold after last char", n, HOLD - 1, HOLD + 1);
    endtask

    task automatic t_send;
        int n;
        rtty_n_i = 1'b0;
        ticks(DEB + 3);
        chk("R9 rx closed in RTTY", rx_open_o, 1'b0);
        chk("R8 tone_gate idle RTTY", tone_gate_o, 1'b0);
        send_n_i = 1'b0;
        ticks(DEB + 3);
        chk("R6 tx_en in SEND", tx_en_o, 1'b1);
        chk("R8 tone_gate in RTTY send", tone_gate_o, 1'b1);
        ticks(1500);
        chk("R6 tx_en held past hold time", tx_en_o, 1'b1);
        send_n_i = 1'b1;
        measure_fall(n);
        chk_rng("R7 drop after leaving SEND", n, DEB + HOLD - 2, DEB + HOLD + 1);
        chk("R8 tone_gate drops with tx", tone_gate_o, 1'b0);
        rtty_n_i = 1'b1;
        ticks(DEB + 3);
        chk("R9 rx reopens in CW", rx_open_o, 1'b1);
    endtask

    task automatic t_glitch;
        logic seen;
        seen = 1'b0;
        key_n_i = 1'b0; ticks(DEB - 3); key_n_i = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (tx_en_o) seen = 1'b1;
        end
        chk("R10 short key glitch ignored", seen, 1'b0);
        seen = 1'b0;
        rtty_n_i = 1'b0; ticks(DEB - 3); rtty_n_i = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!rx_open_o) seen = 1'b1;
        end
        chk("R10 short mode glitch ignored", seen, 1'b0);
    endtask

    initial begin
        t_reset();
        t_key();
        t_retrigger();
        t_char();
        t_send();
        t_glitch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule